// File: doc/BRIEF.md
# Programmable Recirculating Sequence Generator

This block plays back a short pattern of 3-bit values over and over. The pattern has from 1 to 16 steps. The values are held as data, not decoded from a counter. Each output bit has its own 16-entry shift ring. A 4-bit tap select picks which depth of every ring feeds the output, and that same tapped bit is written back into the head of its ring on each shift. Because of this, the tap select directly sets the repeat length: a tap of N gives a period of N+1.

To program the block, the user holds load mode and shifts the pattern in, one 3-bit word per enabled clock. The user then drops load mode and keeps shift enable high, and the stored words come out in the order they were written. The output is registered, so it changes on the clock edge of each run-mode shift and holds at every other time.

Top module: `seq_ring_gen`

## Requirements
- R1: While reset is asserted (rstN low, asynchronous), every ring entry and the output register go to zero. With no load after reset, run mode produces zero for any tap select.
- R2: When loadMode=1 and shiftEn=1, each clock edge moves every ring one entry deeper and writes bit b of dataIn into entry 0 of ring b. The output register holds its value throughout load mode.
- R3: When loadMode=0 and shiftEn=1, each clock edge moves every ring one entry deeper and writes the entry selected by tapSel back into entry 0. With tapSel held constant, the output repeats with a period of tapSel+1.
- R4: After exactly tapSel+1 words are loaded, the run-mode output gives those words in the order they were loaded, starting with the first one.
- R5: On every run-mode enabled edge, seqOut takes the value of the tapped entries as they were before that edge. The first loaded word therefore appears one edge after run mode begins.
- R6: When shiftEn=0, no ring entry changes and seqOut holds. When shifting resumes, the sequence continues from where it paused.
- R7: If more than tapSel+1 words are loaded, only the last tapSel+1 of them form the sequence. The older words are pushed beyond the tap and are ignored.
- R8: The extreme periods work. tapSel=0 repeats the single last loaded word on every step, and tapSel=15 plays back all 16 loaded words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadMode | input | 1 | 1 = shift dataIn into the rings, 0 = recirculate |
| shiftEn | input | 1 | Advances the rings (and, in run mode, the output) |
| dataIn | input | 3 | Word shifted in during load mode; bit b feeds ring b |
| tapSel | input | 4 | Tap depth, equal to the period minus one |
| seqOut | output | 3 | Registered sequence output |

## Verification
The bench loads the 8-word pattern 4,7,2,3,0,1,6,5 with tap 7 and checks three full periods cycle by cycle. Getting the ring direction or the tap index wrong would give a reversed or rotated pattern. An unregistered output would show each word one sample early. The bench also covers the two extreme periods (a single word with tap 0, and a computed 16-word pattern with tap 15), a load of more words than the period (a design that kept the oldest words would play the wrong slice), and a pause of shiftEn during a run (a design that leaked the shift would skip a word). It also runs straight after reset, where any stale ring content would show up as a nonzero output.

// File: rtl/seq_ring_pkg.sv
package seq_ring_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic shiftRing;  // advance every ring one entry
    logic takeInput;  // head entry takes external data instead of the tap
    logic latchOut;   // output register captures the tapped word
  } ringStrobe_t;
endpackage

// File: rtl/seq_ring_ctrl.sv
module seq_ring_ctrl
  import seq_ring_pkg::*;
(
  input  logic        loadMode,
  input  logic        shiftEn,
  output ringStrobe_t strobe
);
  always_comb begin
    strobe.shiftRing = shiftEn;
    strobe.takeInput = loadMode;
    strobe.latchOut  = shiftEn && !loadMode;
  end
endmodule

// File: rtl/seq_ring_dp.sv
module seq_ring_dp
  import seq_ring_pkg::*;
#(
  parameter int LANES = 3,
  parameter int DEPTH = 16,
  localparam int TAP_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ringStrobe_t      strobe,
  input  logic [LANES-1:0] dataIn,
  input  logic [TAP_W-1:0] tapSel,
  output logic [LANES-1:0] seqOut,
  output logic [LANES-1:0] tapBits,
  output logic [LANES-1:0] headBits
);
  // One independent ring per output bit
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [DEPTH-1:0] ring;
    logic             feedBit;

    assign tapBits[lane]  = ring[tapSel];
    assign headBits[lane] = ring[0];
    assign feedBit = strobe.takeInput ? dataIn[lane] : tapBits[lane];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ring <= '0;
      end else if (strobe.shiftRing) begin
        ring <= {ring[DEPTH-2:0], feedBit};
      end
    end
  end

  // Registered output word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqOut <= '0;
    end else if (strobe.latchOut) begin
      seqOut <= tapBits;
    end
  end
endmodule

// File: rtl/seq_ring_gen.sv
module seq_ring_gen
  import seq_ring_pkg::*;
#(
  parameter int LANES = 3,
  parameter int DEPTH = 16,
  localparam int TAP_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadMode,
  input  logic             shiftEn,
  input  logic [LANES-1:0] dataIn,
  input  logic [TAP_W-1:0] tapSel,
  output logic [LANES-1:0] seqOut
);
  ringStrobe_t      strobe;
  logic [LANES-1:0] tapBits;
  logic [LANES-1:0] headBits;

  seq_ring_ctrl u_ctrl (
    .loadMode (loadMode),
    .shiftEn  (shiftEn),
    .strobe   (strobe)
  );

  seq_ring_dp #(.LANES(LANES), .DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dataIn   (dataIn),
    .tapSel   (tapSel),
    .seqOut   (seqOut),
    .tapBits  (tapBits),
    .headBits (headBits)
  );
endmodule

// File: rtl/seq_ring_chk.sv
module seq_ring_chk #(
  parameter int LANES = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadMode,
  input logic             shiftEn,
  input logic [LANES-1:0] dataIn,
  input logic [LANES-1:0] seqOut,
  input logic [LANES-1:0] tapBits,
  input logic [LANES-1:0] headBits
);
  // R1: leaving reset, output and ring heads are clear
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rstN) |-> (seqOut == '0 && headBits == '0));

  // R2: a load shift writes the input word into the ring heads
  assert_load_head_R2: assert property (@(posedge clk) disable iff (!rstN)
    (loadMode && shiftEn) |=> headBits == $past(dataIn));

  // R2: output holds during load mode
  assert_load_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadMode |=> $stable(seqOut));

  // R3: a run shift feeds the tapped word back to the heads
  assert_recirc_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!loadMode && shiftEn) |=> headBits == $past(tapBits));

  // R5: the output captures the pre-edge tapped word
  assert_out_latch_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!loadMode && shiftEn) |=> seqOut == $past(tapBits));

  // R6: nothing moves without shift enable
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !shiftEn |=> ($stable(seqOut) && $stable(headBits)));
endmodule

bind seq_ring_gen seq_ring_chk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .loadMode (loadMode),
  .shiftEn  (shiftEn),
  .dataIn   (dataIn),
  .seqOut   (seqOut),
  .tapBits  (tapBits),
  .headBits (headBits)
);

// File: tb/seq_ring_gen_test.sv
module seq_ring_gen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadMode = 1'b0;
  logic       shiftEn = 1'b0;
  logic [2:0] dataIn = '0;
  logic [3:0] tapSel = '0;
  logic [2:0] seqOut;

  int total = 0;
  int bad = 0;
  int seqBuf[32];
  int seqLen = 0;

  always #4 clk = ~clk;  // 125 MHz

  seq_ring_gen uut (
    .clk(clk), .rstN(rstN), .loadMode(loadMode), .shiftEn(shiftEn),
    .dataIn(dataIn), .tapSel(tapSel), .seqOut(seqOut)
  );

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Shift the words in seqBuf[0..n-1] into the rings (load mode)
  task automatic loadWords(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      loadMode = 1'b1; shiftEn = 1'b1; dataIn = 3'(seqBuf[i]);
    end
    @(negedge clk);
    shiftEn = 1'b0;
    seqLen = n;
  endtask

  // Run n steps with the current tap and compare against the loaded tail
  task automatic runCheck(input string tag, input int steps, input int startStep);
    int per;
    per = int'(tapSel) + 1;
    @(negedge clk);
    loadMode = 1'b0; shiftEn = 1'b1;
    for (int k = 0; k < steps; k++) begin
      @(negedge clk);
      check(tag, int'(seqOut), seqBuf[seqLen - per + ((startStep + k) % per)]);
    end
    shiftEn = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    check("R1 reset output", int'(seqOut), 0);
    rstN = 1'b1;

    // R1: cleared rings play zeros at the longest period
    tapSel = 4'd15;
    @(negedge clk);
    loadMode = 1'b0; shiftEn = 1'b1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      check("R1 zero after reset", int'(seqOut), 0);
    end
    shiftEn = 1'b0;

    // R2/R4/R3/R5: the 8-word pattern, three periods
    seqBuf[0] = 4; seqBuf[1] = 7; seqBuf[2] = 2; seqBuf[3] = 3;
    seqBuf[4] = 0; seqBuf[5] = 1; seqBuf[6] = 6; seqBuf[7] = 5;
    tapSel = 4'd7;
    loadWords(8);
    check("R2 output held during load", int'(seqOut), 0);
    runCheck("R3 R4 R5 period 8", 24, 0);

    // R6: pause mid-run, then resume
    @(negedge clk);
    loadMode = 1'b0; shiftEn = 1'b1;
    repeat (3) @(negedge clk);  // output now shows word index 2
    check("R6 before pause", int'(seqOut), 2);
    shiftEn = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check("R6 hold while idle", int'(seqOut), 2);
    end
    shiftEn = 1'b1;
    @(negedge clk);
    check("R6 resume next word", int'(seqOut), 3);
    @(negedge clk);
    check("R6 resume next word", int'(seqOut), 0);
    shiftEn = 1'b0;
    held = int'(seqOut);

    // R7: ten words with period 8 keep only the last eight
    for (int i = 0; i < 10; i++) seqBuf[i] = (i * 3 + 1) % 8;
    loadWords(10);
    check("R2 output held over reload", int'(seqOut), held);
    runCheck("R7 excess words dropped", 16, 0);

    // R8: period 1
    seqBuf[0] = 6;
    tapSel = 4'd0;
    loadWords(1);
    runCheck("R8 period 1", 5, 0);

    // R8: period 16, computed pattern, two periods
    for (int i = 0; i < 16; i++) seqBuf[i] = (i * 5 + 2) % 8;
    tapSel = 4'd15;
    loadWords(16);
    runCheck("R8 period 16", 32, 0);

    // R1: reset mid-stream clears everything
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset clears output", int'(seqOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    loadMode = 1'b0; shiftEn = 1'b1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      check("R1 rings cleared", int'(seqOut), 0);
    end
    shiftEn = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule